// File: doc/BRIEF.md
# Double-Buffered Video RAM Bank Controller

This block sits inside a video expansion unit for an 8-bit home computer. It holds the unit's display mode register and manages the unit's private video RAM, which is split into two equal banks. The host CPU never addresses the private RAM directly. Instead, the block snoops every host memory write. Any write that lands in the host's screen window is copied into whichever bank the mode register names as the shadow bank. Independently, the video fetch logic reads screen bytes from whichever bank the register names as the display bank.

Software can therefore draw the next frame into one bank while the other is being shown. It then swaps the two bank bits with a single register write, and the picture changes without tearing. A mode write takes effect on the next clock, even in the middle of a frame, so software that wants a clean swap waits for frame start itself.

Reset, or the configuration-enable input going low, forces the register to all zeros. All zeros is the plain default configuration: row mode, bank 0 for both roles, standard border, basic palette, one colour byte per cell and full-width cells.

The bank depth is set by `BANK_AW`. A production build uses 14, which gives two 16K banks and the window 0x4000 to 0x7FFF. The default of 10 keeps elaboration small. With the default, the window runs from `WIN_BASE` (0x4000) to 0x43FF.

Top module: `shadow_bank_ctrl`

## Requirements
- R1: After reset, mode_q is 0x00, every decoded mode output is 0 and vid_rsp_valid is 0.
- R2: A mode write with cfg_enable high is visible on mode_q on the next clock. The decoded outputs follow these fixed bit positions: bit 0 row_col_mode, bit 1 disp_bank, bit 2 shadow_bank, bit 3 alt_border, bit 4 extra_colours, bit 5 double_byte, bit 6 half_cell.
- R3: Bit 7 of mode_q always reads 0, whatever value is written to it.
- R4: While cfg_enable is low, the register is cleared to 0x00 on every clock and mode writes are ignored. It stays 0x00 after cfg_enable returns high, until the next write.
- R5: A snooped CPU write whose address lies in [WIN_BASE, WIN_BASE + 2^BANK_AW) stores its data in the shadow bank at offset (address − WIN_BASE). A write outside that range changes no RAM location, including the location it would alias to if only the low address bits were used.
- R6: A video request accepted on a clock edge (vid_req_valid and vid_req_ready both high) returns the byte at that offset in the current display bank. vid_rsp_valid is high in the following cycle. The display bank is chosen independently of the shadow bank.
- R7: In a cycle where a snooped CPU write falls inside the window, vid_req_ready is low. The CPU write always gets the RAM.
- R8: While vid_rsp_valid is high and vid_rsp_ready is low, vid_rsp_data and vid_rsp_valid hold their values and vid_req_ready is low. The response is released on the first cycle in which vid_rsp_ready is high.
- R9: A change of the display bank bit applies to the very next accepted video request. There is no deferral to a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Configuration enable; low forces the default mode |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | 8 | Mode register write value |
| mode_q | output | 8 | Mode register readback |
| row_col_mode | output | 1 | Mode bit 0: row/column attribute mode |
| disp_bank | output | 1 | Mode bit 1: bank read by video |
| shadow_bank | output | 1 | Mode bit 2: bank receiving CPU copies |
| alt_border | output | 1 | Mode bit 3: alternative border |
| extra_colours | output | 1 | Mode bit 4: 64-colour palette |
| double_byte | output | 1 | Mode bit 5: two colour bytes per cell |
| half_cell | output | 1 | Mode bit 6: 4-pixel-wide cells |
| cpu_wr_valid | input | 1 | Snooped host memory write strobe |
| cpu_wr_addr | input | HOST_AW | Snooped host write address |
| cpu_wr_data | input | DATA_W | Snooped host write data |
| vid_req_valid | input | 1 | Video read request valid |
| vid_req_ready | output | 1 | Video read request accepted |
| vid_req_addr | input | BANK_AW | Offset within the display bank |
| vid_rsp_valid | output | 1 | Read data valid |
| vid_rsp_ready | input | 1 | Read data consumer ready |
| vid_rsp_data | output | DATA_W | Read data |

Back-pressure rules: the snooped CPU bus cannot be stalled and has no ready signal. A video request transfers only on a clock edge where vid_req_valid and vid_req_ready are both high. A response transfers only when vid_rsp_valid and vid_rsp_ready are both high, and only one response is outstanding at a time.

## Verification
The bench writes a byte through one bank and reads it back through the other bank role to show that the two bank bits are independent. A design that tied display to shadow would return the freshly written byte instead of the old one. It also sends writes just below the window and just above it, each aimed at an offset that an address truncated to its low bits would reach. A decoder that only masked the low bits would corrupt those locations. It collides a CPU write with a video request and stalls the response, which exposes a port that lets the read win or drops held data. Finally, it checks that the cleared register stays cleared after cfg_enable returns high, which catches a design that restores the old value.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Mode register layout; bit 0 is the last field.
  typedef struct packed {
    logic rsvd;
    logic half_cell;
    logic dbl_byte;
    logic extra_col;
    logic alt_border;
    logic shadow_bank;
    logic disp_bank;
    logic col_mode;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '0;

endpackage

// File: rtl/sbc_mode_reg.sv
module sbc_mode_reg
  import sbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_enable,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output mode_t       mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_DEFAULT;
    end else if (!cfg_enable) begin
      mode <= MODE_DEFAULT;
    end else if (wr_en) begin
      mode <= mode_t'({1'b0, wr_data[6:0]});
    end
  end

endmodule

// File: rtl/sbc_snoop_decode.sv
module sbc_snoop_decode #(
  parameter int HOST_AW  = 16,
  parameter int BANK_AW  = 10,
  parameter int WIN_BASE = 'h4000
) (
  input  logic               wr_valid,
  input  logic [HOST_AW-1:0] wr_addr,
  input  logic               shadow_bank,
  output logic               hit,
  output logic [BANK_AW:0]   ram_addr
);

  localparam logic [HOST_AW-1:0] BASE_W = HOST_AW'(WIN_BASE);
  localparam logic [HOST_AW:0]   SIZE_W = (HOST_AW+1)'(1) << BANK_AW;

  logic [HOST_AW-1:0] offset;

  always_comb begin
    // Addresses below the base wrap to large offsets and miss.
    offset   = wr_addr - BASE_W;
    hit      = wr_valid && ({1'b0, offset} < SIZE_W);
    ram_addr = {shadow_bank, offset[BANK_AW-1:0]};
  end

endmodule

// File: rtl/sbc_bank_ram.sv
module sbc_bank_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // One port: a cycle either writes or reads. The read data holds
  // until the next read.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/sbc_video_port.sv
module sbc_video_port #(
  parameter int BANK_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [BANK_AW-1:0] req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  input  logic               blocked,
  input  logic               disp_bank,
  output logic               rd_en,
  output logic [BANK_AW:0]   rd_addr
);

  always_comb begin
    req_ready = !blocked && (!rsp_valid || rsp_ready);
    rd_en     = req_valid && req_ready;
    rd_addr   = {disp_bank, req_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (rd_en) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int HOST_AW  = 16,
  parameter int DATA_W   = 8,
  parameter int BANK_AW  = 10,
  parameter int WIN_BASE = 'h4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               mode_wr_en,
  input  logic [7:0]         mode_wr_data,
  output logic [7:0]         mode_q,
  output logic               row_col_mode,
  output logic               disp_bank,
  output logic               shadow_bank,
  output logic               alt_border,
  output logic               extra_colours,
  output logic               double_byte,
  output logic               half_cell,
  input  logic               cpu_wr_valid,
  input  logic [HOST_AW-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0]  cpu_wr_data,
  input  logic               vid_req_valid,
  output logic               vid_req_ready,
  input  logic [BANK_AW-1:0] vid_req_addr,
  output logic               vid_rsp_valid,
  input  logic               vid_rsp_ready,
  output logic [DATA_W-1:0]  vid_rsp_data
);

  localparam int RAM_AW = BANK_AW + 1;

  mode_t             mode;
  logic              cpu_hit;
  logic [RAM_AW-1:0] cpu_ram_addr;
  logic              vid_rd_en;
  logic [RAM_AW-1:0] vid_ram_addr;
  logic              ram_en;
  logic [RAM_AW-1:0] ram_addr;

  sbc_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .wr_en      (mode_wr_en),
    .wr_data    (mode_wr_data),
    .mode       (mode)
  );

  sbc_snoop_decode #(
    .HOST_AW  (HOST_AW),
    .BANK_AW  (BANK_AW),
    .WIN_BASE (WIN_BASE)
  ) u_snoop (
    .wr_valid    (cpu_wr_valid),
    .wr_addr     (cpu_wr_addr),
    .shadow_bank (mode.shadow_bank),
    .hit         (cpu_hit),
    .ram_addr    (cpu_ram_addr)
  );

  sbc_video_port #(
    .BANK_AW (BANK_AW)
  ) u_vport (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (vid_req_valid),
    .req_addr  (vid_req_addr),
    .req_ready (vid_req_ready),
    .rsp_valid (vid_rsp_valid),
    .rsp_ready (vid_rsp_ready),
    .blocked   (cpu_hit),
    .disp_bank (mode.disp_bank),
    .rd_en     (vid_rd_en),
    .rd_addr   (vid_ram_addr)
  );

  // The snooped write owns the port; the video port already backs off.
  always_comb begin
    ram_en   = cpu_hit || vid_rd_en;
    ram_addr = cpu_hit ? cpu_ram_addr : vid_ram_addr;
  end

  sbc_bank_ram #(
    .DATA_W (DATA_W),
    .AW     (RAM_AW)
  ) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (cpu_hit),
    .addr  (ram_addr),
    .wdata (cpu_wr_data),
    .rdata (vid_rsp_data)
  );

  always_comb begin
    mode_q        = mode;
    row_col_mode  = mode.col_mode;
    disp_bank     = mode.disp_bank;
    shadow_bank   = mode.shadow_bank;
    alt_border    = mode.alt_border;
    extra_colours = mode.extra_col;
    double_byte   = mode.dbl_byte;
    half_cell     = mode.half_cell;
  end

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int HOST_AW  = 16,
  parameter int DATA_W   = 8,
  parameter int BANK_AW  = 10,
  parameter int WIN_BASE = 'h4000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_enable,
  input logic               mode_wr_en,
  input logic [7:0]         mode_wr_data,
  input logic [7:0]         mode_q,
  input logic               cpu_wr_valid,
  input logic [HOST_AW-1:0] cpu_wr_addr,
  input logic               vid_req_valid,
  input logic               vid_req_ready,
  input logic               vid_rsp_valid,
  input logic               vid_rsp_ready,
  input logic [DATA_W-1:0]  vid_rsp_data
);

  localparam longint WIN_LO = longint'(WIN_BASE);
  localparam longint WIN_HI = longint'(WIN_BASE) + (longint'(1) << BANK_AW);

  logic in_window;
  assign in_window = cpu_wr_valid &&
                     (longint'(cpu_wr_addr) >= WIN_LO) &&
                     (longint'(cpu_wr_addr) <  WIN_HI);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7] == 1'b0);

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && mode_wr_en) |=> (mode_q == {1'b0, $past(mode_wr_data[6:0])}));

  assert_cfg_off_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (mode_q == 8'h00));

  assert_cpu_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> !vid_req_ready);

  assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req_valid && vid_req_ready) |=> vid_rsp_valid);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rsp_valid && !vid_rsp_ready) |=> (vid_rsp_valid && $stable(vid_rsp_data)));

  assert_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rsp_valid && !vid_rsp_ready) |-> !vid_req_ready);

endmodule

bind shadow_bank_ctrl sbc_checker #(
  .HOST_AW  (HOST_AW),
  .DATA_W   (DATA_W),
  .BANK_AW  (BANK_AW),
  .WIN_BASE (WIN_BASE)
) u_sbc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .mode_wr_en    (mode_wr_en),
  .mode_wr_data  (mode_wr_data),
  .mode_q        (mode_q),
  .cpu_wr_valid  (cpu_wr_valid),
  .cpu_wr_addr   (cpu_wr_addr),
  .vid_req_valid (vid_req_valid),
  .vid_req_ready (vid_req_ready),
  .vid_rsp_valid (vid_rsp_valid),
  .vid_rsp_ready (vid_rsp_ready),
  .vid_rsp_data  (vid_rsp_data)
);

// File: tb/shadow_bank_ctrl_test.sv
`timescale 1ns/1ps
module shadow_bank_ctrl_test;

  localparam int HOST_AW  = 16;
  localparam int DATA_W   = 8;
  localparam int BANK_AW  = 10;
  localparam int WIN_BASE = 'h4000;
  localparam int WIN_SIZE = 1 << BANK_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b1;
  logic mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic [7:0] mode_q;
  logic row_col_mode, disp_bank, shadow_bank, alt_border;
  logic extra_colours, double_byte, half_cell;
  logic cpu_wr_valid = 1'b0;
  logic [HOST_AW-1:0] cpu_wr_addr = '0;
  logic [DATA_W-1:0] cpu_wr_data = '0;
  logic vid_req_valid = 1'b0;
  logic vid_req_ready;
  logic [BANK_AW-1:0] vid_req_addr = '0;
  logic vid_rsp_valid;
  logic vid_rsp_ready = 1'b1;
  logic [DATA_W-1:0] vid_rsp_data;

  always #2 clk = ~clk;

  shadow_bank_ctrl #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W), .BANK_AW(BANK_AW), .WIN_BASE(WIN_BASE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .mode_q(mode_q),
    .row_col_mode(row_col_mode), .disp_bank(disp_bank), .shadow_bank(shadow_bank),
    .alt_border(alt_border), .extra_colours(extra_colours),
    .double_byte(double_byte), .half_cell(half_cell),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .vid_req_valid(vid_req_valid), .vid_req_ready(vid_req_ready),
    .vid_req_addr(vid_req_addr), .vid_rsp_valid(vid_rsp_valid),
    .vid_rsp_ready(vid_rsp_ready), .vid_rsp_data(vid_rsp_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of the mode and both banks
  logic [7:0] m_mode = 8'h00;
  logic [DATA_W-1:0] model [2][WIN_SIZE];

  // Scoreboard
  logic [DATA_W-1:0] exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_mode(input logic [7:0] d);
    @(negedge clk);
    mode_wr_en = 1'b1;
    mode_wr_data = d;
    if (cfg_enable) m_mode = {1'b0, d[6:0]};
    @(negedge clk);
    mode_wr_en = 1'b0;
  endtask

  task automatic cpu_write(input logic [HOST_AW-1:0] a, input logic [DATA_W-1:0] d);
    int off;
    @(negedge clk);
    cpu_wr_valid = 1'b1;
    cpu_wr_addr = a;
    cpu_wr_data = d;
    off = int'(a) - WIN_BASE;
    if (off >= 0 && off < WIN_SIZE) model[m_mode[2]][off] = d;
    @(negedge clk);
    cpu_wr_valid = 1'b0;
  endtask

  task automatic vid_read(input logic [BANK_AW-1:0] a, input string tag);
    @(negedge clk);
    vid_req_valid = 1'b1;
    vid_req_addr = a;
    #1;
    while (!vid_req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model[m_mode[1]][a]);
    tag_q.push_back(tag);
    @(negedge clk);
    vid_req_valid = 1'b0;
  endtask

  // Monitor: pops on each response transfer
  always @(negedge clk) begin
    #1;
    if (rst_n && vid_rsp_valid && vid_rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected response", int'(vid_rsp_data), 0);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vid_rsp_data === e, t, int'(vid_rsp_data), int'(e));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(mode_q == 8'h00, "R1 mode after reset", mode_q, 0);
    check({half_cell, double_byte, extra_colours, alt_border, shadow_bank,
           disp_bank, row_col_mode} == 7'h00, "R1 fields after reset",
          {half_cell, double_byte, extra_colours, alt_border, shadow_bank,
           disp_bank, row_col_mode}, 0);
    check(vid_rsp_valid == 1'b0, "R1 rsp_valid after reset", vid_rsp_valid, 0);

    // R2 field positions, R3 reserved bit
    write_mode(8'h55);
    #1;
    check(mode_q == 8'h55, "R2 readback", mode_q, 8'h55);
    check({half_cell, double_byte, extra_colours, alt_border, shadow_bank,
           disp_bank, row_col_mode} == 7'h55, "R2 decoded fields",
          {half_cell, double_byte, extra_colours, alt_border, shadow_bank,
           disp_bank, row_col_mode}, 8'h55);
    write_mode(8'hFF);
    #1;
    check(mode_q == 8'h7F, "R3 reserved bit", mode_q, 8'h7F);
    write_mode(8'h2A);
    #1;
    check({half_cell, double_byte, extra_colours, alt_border, shadow_bank,
           disp_bank, row_col_mode} == 7'h2A, "R2 decoded fields alt",
          {half_cell, double_byte, extra_colours, alt_border, shadow_bank,
           disp_bank, row_col_mode}, 8'h2A);

    // R4 configuration switch off
    @(negedge clk);
    cfg_enable = 1'b0;
    m_mode = 8'h00;
    @(negedge clk);
    #1;
    check(mode_q == 8'h00, "R4 cleared by cfg off", mode_q, 0);
    write_mode(8'h16);
    #1;
    check(mode_q == 8'h00, "R4 write ignored while off", mode_q, 0);
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
    #1;
    check(mode_q == 8'h00, "R4 stays clear after re-enable", mode_q, 0);

    // R5 shadow writes into bank 0, display bank 0
    cpu_write(16'h4000, 8'hA1);
    cpu_write(16'h4005, 8'hB2);
    cpu_write(16'h43FF, 8'hC3);
    cpu_write(16'h4100, 8'h5A);
    vid_read(10'h000, "R5 bank0 offset 0");
    vid_read(10'h005, "R5 bank0 offset 5");
    vid_read(10'h3FF, "R5 bank0 top offset");
    vid_read(10'h100, "R5 bank0 mid offset");
    // outside the window: would alias to offsets 0 and 0x3FF
    cpu_write(16'h4400, 8'hEE);
    cpu_write(16'h3FFF, 8'hDD);
    vid_read(10'h000, "R5 above window ignored");
    vid_read(10'h3FF, "R5 below window ignored");

    // R6 independence: shadow bank 1, display bank 0
    write_mode(8'h04);
    cpu_write(16'h4005, 8'h77);
    vid_read(10'h005, "R6 display bank0 unaffected by shadow1");
    // R9 immediate switch to display bank 1
    write_mode(8'h06);
    vid_read(10'h005, "R9 switched display bank1");
    write_mode(8'h04);
    vid_read(10'h005, "R9 switched back to bank0");

    // R7 CPU write collides with a video request
    write_mode(8'h06);
    @(negedge clk);
    cpu_wr_valid = 1'b1;
    cpu_wr_addr = 16'h4010;
    cpu_wr_data = 8'h3C;
    model[1][16] = 8'h3C;
    vid_req_valid = 1'b1;
    vid_req_addr = 10'h005;
    #1;
    check(vid_req_ready == 1'b0, "R7 ready low during cpu write", vid_req_ready, 0);
    @(negedge clk);
    cpu_wr_valid = 1'b0;
    vid_req_valid = 1'b0;
    vid_read(10'h010, "R7 cpu write landed");

    // R8 back-pressure
    repeat (3) @(negedge clk);
    vid_rsp_ready = 1'b0;
    vid_read(10'h005, "R8 stalled response data");
    #1;
    check(vid_rsp_valid == 1'b1, "R8 valid held", vid_rsp_valid, 1);
    check(vid_req_ready == 1'b0, "R8 ready low while stalled", vid_req_ready, 0);
    held = vid_rsp_data;
    @(negedge clk);
    #1;
    check(vid_rsp_data == held && vid_rsp_valid, "R8 data stable", vid_rsp_data, held);
    @(negedge clk);
    vid_rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(vid_rsp_valid == 1'b0, "R8 released", vid_rsp_valid, 0);
    check(exp_q.size() == 0, "R6 all responses delivered", exp_q.size(), 0);

    finish_run();
  end

endmodule